// File: doc/BRIEF.md
# Delay-Line Phase Tracking Controller

This controller picks a 9-bit setting for a tapped clock delay line. It moves the setting until a measured phase offset between two clock domains settles on a programmed target, and then holds it there. A phase detector delivers a quantized phase sample together with a sample-valid strobe. On the phase scale, 32 counts make one full clock cycle and 16 counts make half a cycle. The controller compares each sample with the target phase. The difference wraps modulo 32 and is read as a signed value from -16 to +15.

When enabled, the controller starts at a programmable code and searches one code at a time. It moves in whichever direction brings the phase toward the target on the selected slope. A slope is either "phase rises with code" or "phase falls with code". Phases inside a small keep-out window near zero never count as a match. Guard bands at both ends of the code range end the search with a failure if the search would step into them. Once the controller has locked, it tracks drift one code per sample. If the error stays large for a sustained period, it drops back into search.

States and transitions: IDLE (code 0) goes to SEARCH (code 1) when `en` is high. SEARCH goes to LOCKED_TRACK (code 2) on the lock condition, or to FAIL (code 3) on a guard hit. LOCKED_TRACK goes back to SEARCH on loss of lock. Any state returns to IDLE when `en` is low.

Top module: `dly_phase_tracker`

## Requirements
- R1: `dly_code` never exceeds 432. A start code above 432 is loaded as 432.
- R2: A synchronous reset, or `en` low on a clock edge, puts the controller in IDLE. In IDLE, `state_o` is 0, `dly_code` is the (clamped) start code, and `locked`, `fail` and `lost_lock` are 0. With `en` high, IDLE moves to SEARCH (`state_o` = 1) on the next edge.
- R3: In SEARCH, each edge with `smp_vld` high and no match steps the code by exactly 1. The step goes up when the signed error (phase minus target, mod 32) is positive on a falling slope, or when it is zero or negative on a rising slope. Otherwise the step goes down. When `smp_vld` is low, the code holds.
- R4: Lock is declared on the fourth consecutive valid sample whose error is within ±1 and which is outside the keep-out window. On that edge the state becomes LOCKED_TRACK (`state_o` = 2) and `locked` = 1. During matching samples the code holds.
- R5: A phase value less than or equal to `cfg_keepout` (0 to 2) never counts as a match.
- R6: A down step from a code at or below `cfg_guard`, or an up step from a code at or above 432 - `cfg_guard`, sends SEARCH to FAIL (`state_o` = 3, `fail` = 1) instead. The code is left unchanged.
- R7: In LOCKED_TRACK, each valid sample with a non-zero error moves the code by 1 toward the target. A zero error holds the code, and `locked` stays 1.
- R8: Eight consecutive valid samples with an error magnitude above 3, or with a phase in the keep-out window, cause a return to SEARCH from the current code. On that edge `lost_lock` = 1 and `locked` = 0.
- R9: FAIL is held, with the code frozen, until `en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces IDLE |
| smp_vld | input | 1 | Phase sample valid strobe |
| smp_phase | input | 5 | Quantized phase sample, 32 counts per cycle |
| cfg_start | input | 9 | Search start code |
| cfg_target | input | 5 | Target phase |
| cfg_slope_fall | input | 1 | 1: phase falls as code rises |
| cfg_guard | input | 9 | Guard band width in codes at each end |
| cfg_keepout | input | 2 | Keep-out window upper phase (0..2) |
| dly_code | output | 9 | Delay line code |
| locked | output | 1 | Lock achieved, tracking |
| fail | output | 1 | Search hit a guard band |
| lost_lock | output | 1 | Lock was lost during tracking |
| state_o | output | 2 | Current state encoding |

## Verification
The bench builds the controller with its default parameters: a 432-code range, a 32-count phase scale, a 4-sample lock run and an 8-sample loss run. With these values, every search in the bench completes within a few hundred cycles. The bench models the phase as a sawtooth of code/8 plus an offset, on both rising and falling slopes. This model places the lock codes, the keep-out outcome and both guard failures at exact, precomputed codes. Shifting the model's offset while the controller is locked brings within reach both small-drift tracking and the exact eighth-sample loss of lock.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2,
        ST_FAIL   = 2'd3
    } dpt_state_e;
endpackage

// File: rtl/dpt_phase_eval.sv
// Wrapped signed phase error and its classification.
module dpt_phase_eval #(
    parameter int PH_W     = 5,
    parameter int KO_W     = 2,
    parameter int TOL_NEAR = 1,
    parameter int TOL_FAR  = 3
) (
    input  logic [PH_W-1:0] phase,
    input  logic [PH_W-1:0] target,
    input  logic [KO_W-1:0] keepout,
    output logic            err_pos,
    output logic            err_zero,
    output logic            near,
    output logic            far
);
    logic [PH_W-1:0] diff;
    logic [PH_W-1:0] mag;
    logic            in_ko;

    always_comb begin
        diff     = phase - target;
        mag      = diff[PH_W-1] ? (~diff + 1'b1) : diff;
        in_ko    = (phase <= PH_W'(keepout));
        err_pos  = !diff[PH_W-1] && (diff != '0);
        err_zero = (diff == '0);
        near     = !in_ko && (mag <= PH_W'(TOL_NEAR));
        far      = in_ko || (mag > PH_W'(TOL_FAR));
    end
endmodule

// File: rtl/dpt_run_cnt.sv
// Counts consecutive qualifying samples; done on the LEN-th.
module dpt_run_cnt #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic hit,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt_q;

    assign done = inc && hit && (cnt_q == CW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= (hit && !done) ? cnt_q + 1'b1 : '0;
    end
endmodule

// File: rtl/dpt_code_step.sv
// Next code for a one-code step and the limits that block it.
module dpt_code_step #(
    parameter int CODE_W   = 9,
    parameter int CODE_MAX = 432
) (
    input  logic [CODE_W-1:0] code,
    input  logic              up,
    input  logic [CODE_W-1:0] guard,
    output logic [CODE_W-1:0] code_nxt,
    output logic              blk_guard,
    output logic              blk_edge
);
    localparam logic [CODE_W:0] MAXV = (CODE_W+1)'(CODE_MAX);
    logic [CODE_W:0] hi_lim;

    always_comb begin
        hi_lim    = (MAXV >= {1'b0, guard}) ? MAXV - {1'b0, guard} : '0;
        code_nxt  = up ? code + 1'b1 : code - 1'b1;
        blk_guard = up ? ({1'b0, code} >= hi_lim) : (code <= guard);
        blk_edge  = up ? ({1'b0, code} >= MAXV) : (code == '0);
    end
endmodule

// File: rtl/dly_phase_tracker.sv
module dly_phase_tracker
    import dpt_pkg::*;
#(
    parameter int CODE_W   = 9,
    parameter int CODE_MAX = 432,
    parameter int PH_W     = 5,
    parameter int KO_W     = 2,
    parameter int LOCK_RUN = 4,
    parameter int LOSS_RUN = 8,
    parameter int TOL_NEAR = 1,
    parameter int TOL_FAR  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              smp_vld,
    input  logic [PH_W-1:0]   smp_phase,
    input  logic [CODE_W-1:0] cfg_start,
    input  logic [PH_W-1:0]   cfg_target,
    input  logic              cfg_slope_fall,
    input  logic [CODE_W-1:0] cfg_guard,
    input  logic [KO_W-1:0]   cfg_keepout,
    output logic [CODE_W-1:0] dly_code,
    output logic              locked,
    output logic              fail,
    output logic              lost_lock,
    output logic [1:0]        state_o
);
    localparam logic [CODE_W-1:0] MAXC = CODE_W'(CODE_MAX);

    dpt_state_e        state_q, state_d;
    logic [CODE_W-1:0] start_c, code_nxt;
    logic              err_pos, err_zero, near, far;
    logic              step_up, blk_guard, blk_edge;
    logic              lock_done, loss_done;
    logic              in_search, in_track;

    assign start_c   = (cfg_start > MAXC) ? MAXC : cfg_start;
    assign step_up   = (err_pos == cfg_slope_fall);
    assign in_search = (state_q == ST_SEARCH);
    assign in_track  = (state_q == ST_TRACK);

    dpt_phase_eval #(.PH_W(PH_W), .KO_W(KO_W), .TOL_NEAR(TOL_NEAR), .TOL_FAR(TOL_FAR)) u_eval (
        .phase(smp_phase), .target(cfg_target), .keepout(cfg_keepout),
        .err_pos(err_pos), .err_zero(err_zero), .near(near), .far(far)
    );

    dpt_code_step #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_step (
        .code(dly_code), .up(step_up), .guard(cfg_guard),
        .code_nxt(code_nxt), .blk_guard(blk_guard), .blk_edge(blk_edge)
    );

    dpt_run_cnt #(.LEN(LOCK_RUN)) u_lock_run (
        .clk(clk), .rst(rst), .clr(!in_search),
        .inc(in_search && smp_vld), .hit(near), .done(lock_done)
    );

    dpt_run_cnt #(.LEN(LOSS_RUN)) u_loss_run (
        .clk(clk), .rst(rst), .clr(!in_track),
        .inc(in_track && smp_vld), .hit(far), .done(loss_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (!en)
                    state_d = ST_IDLE;
                else if (smp_vld && lock_done)
                    state_d = ST_TRACK;
                else if (smp_vld && !near && blk_guard)
                    state_d = ST_FAIL;
            end
            ST_TRACK: begin
                if (!en)
                    state_d = ST_IDLE;
                else if (smp_vld && loss_done)
                    state_d = ST_SEARCH;
            end
            ST_FAIL:   if (!en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_code  <= start_c;
            locked    <= 1'b0;
            fail      <= 1'b0;
            lost_lock <= 1'b0;
        end else begin
            locked <= (state_d == ST_TRACK);
            fail   <= (state_d == ST_FAIL);
            if (state_d == ST_IDLE)
                dly_code <= start_c;
            else if (in_search && state_d == ST_SEARCH && smp_vld && !near)
                dly_code <= code_nxt;
            else if (in_track && smp_vld && !err_zero && !blk_edge)
                dly_code <= code_nxt;
            if (state_d == ST_IDLE || state_d == ST_TRACK)
                lost_lock <= 1'b0;
            else if (in_track && state_d == ST_SEARCH)
                lost_lock <= 1'b1;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
    parameter int CODE_W   = 9,
    parameter int CODE_MAX = 432
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              smp_vld,
    input logic [CODE_W-1:0] cfg_guard,
    input logic [CODE_W-1:0] dly_code,
    input logic              locked,
    input logic              fail,
    input logic [1:0]        state_o
);
    logic [CODE_W:0] hi_lim;
    assign hi_lim = (CODE_MAX >= int'(cfg_guard)) ? (CODE_W+1)'(CODE_MAX - int'(cfg_guard)) : '0;

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(dly_code) <= CODE_MAX);                                        // R1
    AST_IDLE_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> state_o == 2'd0);                                            // R2
    AST_SEARCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && en && !smp_vld) |=> $stable(dly_code));          // R3
    AST_LOCK_FROM_SEARCH: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(state_o) == 2'd1);                           // R4
    AST_FAIL_AT_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (dly_code <= cfg_guard || {1'b0, dly_code} >= hi_lim)); // R6
    AST_TRACK_STEP: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'd2 |=> (state_o != 2'd2 || dly_code == $past(dly_code)
            || dly_code == $past(dly_code) + 1'b1 || dly_code == $past(dly_code) - 1'b1)); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(locked && fail));                                                  // R9
endmodule

bind dly_phase_tracker dpt_checker #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_chk (
    .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld), .cfg_guard(cfg_guard),
    .dly_code(dly_code), .locked(locked), .fail(fail), .state_o(state_o)
);

// File: tb/dly_phase_tracker_tb_top.sv
`timescale 1ns/1ps
module dly_phase_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst, en, smp_vld, cfg_slope_fall;
    logic [4:0] smp_phase, cfg_target;
    logic [8:0] cfg_start, cfg_guard, dly_code;
    logic [1:0] cfg_keepout, state_o;
    logic       locked, fail, lost_lock;
    int         m_off;
    int         checks = 0;
    int         failures = 0;

    always #2.5 clk = ~clk;

    dly_phase_tracker dut_i (
        .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld), .smp_phase(smp_phase),
        .cfg_start(cfg_start), .cfg_target(cfg_target), .cfg_slope_fall(cfg_slope_fall),
        .cfg_guard(cfg_guard), .cfg_keepout(cfg_keepout), .dly_code(dly_code),
        .locked(locked), .fail(fail), .lost_lock(lost_lock), .state_o(state_o)
    );

    // Phase curve model: sawtooth of code/8 plus offset
    always_comb begin
        if (cfg_slope_fall) smp_phase = 5'((m_off - int'(dly_code >> 3)) & 31);
        else                smp_phase = 5'((int'(dly_code >> 3) + m_off) & 31);
    end

    // columns: start, target, fall, offset, keepout, exp_fail, exp_code
    localparam int NV = 7;
    localparam int VEC [NV][7] = '{
        '{100, 6, 0,  0, 0, 0,  63},   // R3 R4 down to lock
        '{ 10, 6, 0,  0, 2, 0,  40},   // R3 R4 up through keep-out
        '{200, 6, 1, 20, 0, 0, 127},   // R3 R4 falling slope with wrap
        '{ 40, 1, 0,  0, 2, 1,  16},   // R5 keep-out blocks match, lower guard
        '{ 40, 1, 0,  0, 0, 0,  23},   // R5 same curve without keep-out locks
        '{400, 6, 1,  0, 0, 1, 416},   // R6 upper guard
        '{ 20,20, 0,  0, 0, 1,  16}    // R6 lower guard, wrapped error
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input int i);
        en = 1'b0; smp_vld = 1'b0;
        cfg_start = 9'(VEC[i][0]); cfg_target = 5'(VEC[i][1]);
        cfg_slope_fall = VEC[i][2][0]; m_off = VEC[i][3];
        cfg_keepout = 2'(VEC[i][4]);
        cyc(2);
        en = 1'b1; smp_vld = 1'b1;
        for (int k = 0; k < 3000 && !locked && !fail; k++) cyc(1);
        chk("R4/R6 fail flag", int'(fail), VEC[i][5]);
        chk("R3/R4/R6 final code", int'(dly_code), VEC[i][6]);
        chk("R4/R6 state", int'(state_o), VEC[i][5] != 0 ? 3 : 2);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; smp_vld = 1'b0; m_off = 0;
        cfg_start = 9'd100; cfg_target = 5'd6; cfg_slope_fall = 1'b0;
        cfg_guard = 9'd16; cfg_keepout = 2'd0;
        @(negedge clk);
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R2 reset state
        chk("R2 reset state", int'(state_o), 0);
        chk("R2 reset code", int'(dly_code), 100);
        chk("R2 reset locked", int'(locked), 0);
        chk("R2 reset fail", int'(fail), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9 fail held until disable
        smp_vld = 1'b1;
        cyc(20);
        chk("R9 fail held state", int'(state_o), 3);
        chk("R9 fail held code", int'(dly_code), 16);

        // R1 start clamp in idle
        en = 1'b0; cfg_start = 9'd500;
        cyc(2);
        chk("R1 clamp code", int'(dly_code), 432);
        chk("R2 idle after disable", int'(state_o), 0);

        // R3 hold while no valid sample
        cfg_start = 9'd100; cfg_target = 5'd6; cfg_slope_fall = 1'b0;
        m_off = 0; cfg_keepout = 2'd0; smp_vld = 1'b0;
        cyc(2);
        en = 1'b1;
        cyc(6);
        chk("R2 enable enters search", int'(state_o), 1);
        chk("R3 code holds without valid", int'(dly_code), 100);

        // relock, then drift by one phase step
        smp_vld = 1'b1;
        for (int k = 0; k < 3000 && !locked; k++) cyc(1);
        chk("R4 relock code", int'(dly_code), 63);
        m_off = 1;
        cyc(40);
        chk("R7 tracked code", int'(dly_code), 47);
        chk("R7 still locked", int'(locked), 1);

        // R8 loss of lock on the eighth far sample
        m_off = 11;
        cyc(7);
        chk("R8 locked after 7 far", int'(locked), 1);
        cyc(1);
        chk("R8 locked after 8 far", int'(locked), 0);
        chk("R8 lost flag", int'(lost_lock), 1);
        chk("R8 back to search", int'(state_o), 1);

        // R2 disable clears everything
        en = 1'b0;
        cyc(1);
        chk("R2 disable state", int'(state_o), 0);
        chk("R2 disable lost cleared", int'(lost_lock), 0);
        chk("R2 disable code", int'(dly_code), 100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule